// File: doc/BRIEF.md
# Network DMA Interrupt Status and Mask Unit

This block collects completion and resource events from the transmit and receive engines of a network DMA controller and turns them into one level interrupt. Each engine raises single-cycle event pulses. The pulses set bits in a sticky status register for that direction, and software clears those bits by writing ones. A fixed set of status bits is decoded into interrupt causes. A cause is copied into a latched interrupt status register only when its mask bit is clear.

Software changes the mask through two write-only ports. One port clears mask bits and the other sets them. The mask itself can only be read. Reading the interrupt status register returns its value and empties it in the same step. The interrupt output is the OR of the latched bits.

Causes are sampled on trigger cycles only. A trigger cycle is any cycle with a nonzero event pulse, or with a register write to the transmit status, receive status, enable or disable port. On a trigger cycle the unit uses the status and mask values that the same edge produces. Because of this, a cause that is still pending is latched again as soon as the interrupt is enabled.

Top module: `net_irq_unit`

## Requirements
- R1: After reset the transmit status, receive status and interrupt status all read 0, the mask reads 0x07FFFFFF and irq_o is low.
- R2: An event pulse sets the matching status bit, and the bit then holds until software clears it. In the 9-bit transmit status only the bits in 0x1F7 can be set, so bit 3 stays 0. In the 4-bit receive status all bits can be set.
- R3: A register write clears each status bit that has a 1 in the write data. If an event sets the same bit in the same cycle, the set wins.
- R4: Causes are mapped as follows. Transmit status bit 5 drives interrupt bit 7 and transmit status bit 0 drives interrupt bit 3. Receive status bit 1 drives interrupt bit 1 and receive status bit 0 drives interrupt bit 2.
- R5: On a trigger cycle, each cause whose next-state mask bit is 0 is ORed into the interrupt status register. Masked causes and non-trigger cycles add no bits.
- R6: Writing to the enable port (offset 4) clears the mask bits where the data is 1. Writing to the disable port (offset 5) sets them. Only data bits 26:0 take effect, and both ports read back 0.
- R7: Reading the interrupt status register (offset 2) returns its value and clears every bit on the same edge. The next trigger can set bits again.
- R8: irq_o is high exactly when any interrupt status bit is set.
- R9: Read data appears on reg_rdata_o on the edge that samples reg_re_i and is held until the next read. The offsets are 0 for transmit status, 1 for receive status, 2 for interrupt status and 3 for the mask. Unmapped offsets read 0.
- R10: Writes to the interrupt status register (offset 2) and to the mask (offset 3) change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 3 | Word offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, registered |
| tx_evt_i | input | 9 | Transmit engine event pulses, one per status bit |
| rx_evt_i | input | 4 | Receive engine event pulses, one per status bit |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions assume one register write per cycle, so the enable and disable ports are never written in the same cycle. This follows from the single address bus. The bound on the disable-port assertion also relies on that. The assertions do not assume that event pulses avoid the cycles in which software clears the same status bits. The random stimulus therefore lets sparse event pulses collide freely with status writes and with reads of the interrupt status register. Read strobes and write strobes are drawn independently, so a read and a write can land in the same cycle.

// File: rtl/net_irq_pkg.sv
package net_irq_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned TX_W   = 9;
  localparam int unsigned RX_W   = 4;
  localparam int unsigned MASK_W = 27;

  localparam logic [TX_W-1:0] TX_CLR_MASK = 9'h1F7;
  localparam logic [RX_W-1:0] RX_CLR_MASK = 4'hF;

  localparam logic [ADDR_W-1:0] OFF_TX   = 3'd0;
  localparam logic [ADDR_W-1:0] OFF_RX   = 3'd1;
  localparam logic [ADDR_W-1:0] OFF_ISR  = 3'd2;
  localparam logic [ADDR_W-1:0] OFF_MASK = 3'd3;
  localparam logic [ADDR_W-1:0] OFF_EN   = 3'd4;
  localparam logic [ADDR_W-1:0] OFF_DIS  = 3'd5;

  // status bit -> interrupt bit
  localparam int unsigned TX_DONE_SB  = 5;
  localparam int unsigned TX_USED_SB  = 0;
  localparam int unsigned RX_FRAME_SB = 1;
  localparam int unsigned RX_NOBUF_SB = 0;
  localparam int unsigned INT_TX_DONE  = 7;
  localparam int unsigned INT_TX_USED  = 3;
  localparam int unsigned INT_RX_FRAME = 1;
  localparam int unsigned INT_RX_NOBUF = 2;

  localparam logic [MASK_W-1:0] MASK_RST = {MASK_W{1'b1}};
endpackage

// File: rtl/irq_sticky_stat.sv
module irq_sticky_stat #(
  parameter int unsigned W = 4,
  parameter logic [W-1:0] CLR_MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] d_o,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  // set beats clear on the same bit
  assign d_o = (q & ~(clr_i & CLR_MASK)) | (set_i & CLR_MASK);
  assign q_o = q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) q <= '0;
    else         q <= d_o;

  assert_set_wins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(set_i & CLR_MASK)) |=> ((q & $past(set_i & CLR_MASK)) == $past(set_i & CLR_MASK)));

  assert_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i == '0) |=> ((q & $past(q)) == $past(q)));
endmodule

// File: rtl/irq_mask_ctl.sv
module irq_mask_ctl #(
  parameter int unsigned MW = 27,
  parameter logic [MW-1:0] RST = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_we_i,
  input  logic          dis_we_i,
  input  logic [MW-1:0] wdata_i,
  output logic [MW-1:0] d_o,
  output logic [MW-1:0] q_o
);
  logic [MW-1:0] q;

  always_comb begin
    d_o = q;
    if (en_we_i)  d_o = d_o & ~wdata_i;
    if (dis_we_i) d_o = d_o | wdata_i;
  end
  assign q_o = q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) q <= RST;
    else         q <= d_o;

  assert_enable_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_we_i && !dis_we_i) |=> ((q & $past(wdata_i)) == '0));

  assert_disable_sets_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_we_i |=> ((q & $past(wdata_i)) == $past(wdata_i)));

  assert_mask_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_we_i && !dis_we_i) |=> $stable(q));
endmodule

// File: rtl/irq_latch.sv
module irq_latch #(
  parameter int unsigned MW = 27
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          trig_i,
  input  logic          rd_clr_i,
  input  logic [MW-1:0] cause_i,
  input  logic [MW-1:0] mask_i,
  output logic [MW-1:0] q_o,
  output logic          irq_o
);
  logic [MW-1:0] q, d;

  always_comb begin
    d = rd_clr_i ? '0 : q;
    if (trig_i) d = d | (cause_i & ~mask_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) q <= '0;
    else         q <= d;

  assign q_o   = q;
  assign irq_o = |q;

  assert_read_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && !trig_i) |=> (q == '0));

  assert_no_set_off_trigger_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig_i |=> ((q & ~$past(q)) == '0));

  assert_masked_stays_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_clr_i |=> ((q & $past(mask_i)) == '0));
endmodule

// File: rtl/net_irq_unit.sv
module net_irq_unit
  import net_irq_pkg::*;
#(
  parameter int unsigned AW  = ADDR_W,
  parameter int unsigned DW  = DATA_W,
  parameter int unsigned TXW = TX_W,
  parameter int unsigned RXW = RX_W,
  parameter int unsigned MW  = MASK_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           reg_we_i,
  input  logic           reg_re_i,
  input  logic [AW-1:0]  reg_addr_i,
  input  logic [DW-1:0]  reg_wdata_i,
  output logic [DW-1:0]  reg_rdata_o,
  input  logic [TXW-1:0] tx_evt_i,
  input  logic [RXW-1:0] rx_evt_i,
  output logic           irq_o
);
  logic wr_tx, wr_rx, wr_en, wr_dis, rd_isr, trig;
  logic [TXW-1:0] tx_d, tx_q;
  logic [RXW-1:0] rx_d, rx_q;
  logic [MW-1:0]  mask_d, mask_q, isr_q, cause;
  logic [DW-1:0]  rdata_q, rd_mux;
  logic unused_wdata;

  assign wr_tx  = reg_we_i && reg_addr_i == OFF_TX;
  assign wr_rx  = reg_we_i && reg_addr_i == OFF_RX;
  assign wr_en  = reg_we_i && reg_addr_i == OFF_EN;
  assign wr_dis = reg_we_i && reg_addr_i == OFF_DIS;
  assign rd_isr = reg_re_i && reg_addr_i == OFF_ISR;
  assign trig   = (|tx_evt_i) || (|rx_evt_i) || wr_tx || wr_rx || wr_en || wr_dis;
  assign unused_wdata = ^reg_wdata_i[DW-1:MW];

  irq_sticky_stat #(.W(TXW), .CLR_MASK(TX_CLR_MASK)) u_tx_stat (
    .clk_i, .rst_ni, .set_i(tx_evt_i),
    .clr_i(wr_tx ? reg_wdata_i[TXW-1:0] : '0), .d_o(tx_d), .q_o(tx_q));

  irq_sticky_stat #(.W(RXW), .CLR_MASK(RX_CLR_MASK)) u_rx_stat (
    .clk_i, .rst_ni, .set_i(rx_evt_i),
    .clr_i(wr_rx ? reg_wdata_i[RXW-1:0] : '0), .d_o(rx_d), .q_o(rx_q));

  irq_mask_ctl #(.MW(MW), .RST(MASK_RST)) u_mask (
    .clk_i, .rst_ni, .en_we_i(wr_en), .dis_we_i(wr_dis),
    .wdata_i(reg_wdata_i[MW-1:0]), .d_o(mask_d), .q_o(mask_q));

  always_comb begin
    cause = '0;
    cause[INT_TX_DONE]  = tx_d[TX_DONE_SB];
    cause[INT_TX_USED]  = tx_d[TX_USED_SB];
    cause[INT_RX_FRAME] = rx_d[RX_FRAME_SB];
    cause[INT_RX_NOBUF] = rx_d[RX_NOBUF_SB];
  end

  irq_latch #(.MW(MW)) u_latch (
    .clk_i, .rst_ni, .trig_i(trig), .rd_clr_i(rd_isr),
    .cause_i(cause), .mask_i(mask_d), .q_o(isr_q), .irq_o(irq_o));

  always_comb begin
    unique case (reg_addr_i)
      OFF_TX:   rd_mux = DW'(tx_q);
      OFF_RX:   rd_mux = DW'(rx_q);
      OFF_ISR:  rd_mux = DW'(isr_q);
      OFF_MASK: rd_mux = DW'(mask_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)       rdata_q <= '0;
    else if (reg_re_i) rdata_q <= rd_mux;

  assign reg_rdata_o = rdata_q;

  assert_isr_read_value_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_isr |=> (reg_rdata_o == DW'($past(isr_q))));

  assert_rdata_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_re_i |=> $stable(reg_rdata_o));
endmodule

// File: tb/sim_net_irq_unit.sv
module sim_net_irq_unit;
  import net_irq_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, we, re, irq;
  logic [2:0] addr;
  logic [31:0] wdata, rdata;
  logic [8:0] txe;
  logic [3:0] rxe;

  net_irq_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .tx_evt_i(txe), .rx_evt_i(rxe), .irq_o(irq));

  int checks = 0, errors = 0;
  logic [8:0]  m_tx;
  logic [3:0]  m_rx;
  logic [26:0] m_isr, m_mask;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [26:0] cause_of(input logic [8:0] t, input logic [3:0] r);
    logic [26:0] c = '0;
    c[7] = t[5]; c[3] = t[0]; c[1] = r[1]; c[2] = r[0];  // R4
    return c;
  endfunction

  function automatic logic [31:0] read_of(input logic [2:0] a);
    case (a)
      3'd0: return {23'd0, m_tx};
      3'd1: return {28'd0, m_rx};
      3'd2: return {5'd0, m_isr};
      3'd3: return {5'd0, m_mask};
      default: return 32'd0;
    endcase
  endfunction

  // one cycle, starting and ending at a falling edge
  task automatic step(input logic w, input logic r, input logic [2:0] a, input logic [31:0] d,
                      input logic [8:0] te, input logic [3:0] re_ev, input string tag);
    logic [8:0] tx_n; logic [3:0] rx_n; logic [26:0] mk_n, is_n; logic trg;
    logic [31:0] exp_rd;
    we = w; re = r; addr = a; wdata = d; txe = te; rxe = re_ev;
    exp_rd = read_of(a);
    tx_n = (m_tx & ~((w && a == 3'd0) ? d[8:0] & 9'h1F7 : 9'h0)) | (te & 9'h1F7);
    rx_n = (m_rx & ~((w && a == 3'd1) ? d[3:0] : 4'h0)) | re_ev;
    mk_n = m_mask;
    if (w && a == 3'd4) mk_n = mk_n & ~d[26:0];
    if (w && a == 3'd5) mk_n = mk_n | d[26:0];
    trg = (|te) || (|re_ev) || (w && (a == 3'd0 || a == 3'd1 || a == 3'd4 || a == 3'd5));
    is_n = (r && a == 3'd2) ? 27'd0 : m_isr;
    if (trg) is_n = is_n | (cause_of(tx_n, rx_n) & ~mk_n);
    @(posedge clk); #2;
    if (r) chk({tag, " rdata R9"}, rdata, exp_rd);
    chk({tag, " irq R8"}, {31'd0, irq}, {31'd0, |is_n});
    m_tx = tx_n; m_rx = rx_n; m_mask = mk_n; m_isr = is_n;
    @(negedge clk);
    we = 0; re = 0; txe = '0; rxe = '0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input string tag);
    step(1'b1, 1'b0, a, d, '0, '0, tag);
  endtask

  task automatic rd_expect(input logic [2:0] a, input logic [31:0] lit, input string tag);
    step(1'b0, 1'b1, a, '0, '0, '0, tag);
    chk({tag, " literal"}, rdata, lit);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; we = 0; re = 0; addr = '0; wdata = '0; txe = '0; rxe = '0;
    m_tx = '0; m_rx = '0; m_isr = '0; m_mask = 27'h7FFFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    rd_expect(3'd0, 32'h0, "R1 tx status");
    rd_expect(3'd1, 32'h0, "R1 rx status");
    rd_expect(3'd2, 32'h0, "R1 isr");
    rd_expect(3'd3, 32'h07FFFFFF, "R1 mask");
    step(0, 0, 3'd0, 0, 9'h020, 4'h0, "R5 masked event");
    rd_expect(3'd2, 32'h0, "R5 masked cause not latched");
    rd_expect(3'd0, 32'h20, "R2 tx bit5 set");
    step(0, 0, 3'd0, 0, 9'h008, 4'h0, "R2 bit3 event");
    rd_expect(3'd0, 32'h20, "R2 tx bit3 not stored");
    wr(3'd4, 32'hFFFFFFFF, "R6 enable all");
    chk("R8 irq after enable", {31'd0, irq}, 32'd1);
    rd_expect(3'd3, 32'h0, "R6 mask cleared");
    rd_expect(3'd4, 32'h0, "R6 enable reads 0");
    rd_expect(3'd5, 32'h0, "R6 disable reads 0");
    rd_expect(3'd2, 32'h80, "R4 tx done to bit7");
    chk("R7 irq dropped", {31'd0, irq}, 32'd0);
    rd_expect(3'd2, 32'h0, "R7 isr cleared");
    wr(3'd5, 32'hF8000004, "R6 disable bit2");
    rd_expect(3'd3, 32'h4, "R6 mask upper ignored");
    rd_expect(3'd2, 32'h80, "R5 retrigger on disable write");
    step(0, 0, 3'd0, 0, 9'h0, 4'h1, "R5 nobuf masked");
    rd_expect(3'd2, 32'h80, "R5 bit2 masked");
    step(1, 0, 3'd0, 32'h1, 9'h001, 4'h0, "R3 collide");
    rd_expect(3'd0, 32'h21, "R3 set wins");
    rd_expect(3'd2, 32'h88, "R4 tx used to bit3");
    wr(3'd0, 32'hFFFFFFFF, "R3 clear tx");
    rd_expect(3'd0, 32'h0, "R3 tx cleared");
    wr(3'd2, 32'hFFFFFFFF, "R10 write isr");
    wr(3'd3, 32'hFFFFFFFF, "R10 write mask");
    rd_expect(3'd2, 32'h0, "R10 isr unchanged");
    rd_expect(3'd3, 32'h4, "R10 mask unchanged");
    wr(3'd1, 32'hF, "R3 clear rx");
    step(0, 0, 3'd0, 0, 9'h0, 4'h2, "R4 rx frame");
    rd_expect(3'd2, 32'h2, "R4 rx frame to bit1");
    rd_expect(3'd1, 32'h2, "R2 rx status");
    for (int i = 0; i < 4000; i++) begin
      logic w, r; logic [2:0] a; logic [31:0] d; logic [8:0] te; logic [3:0] rv;
      w  = ($urandom % 3) == 0;
      r  = ($urandom % 2) == 0;
      a  = 3'($urandom % 7);
      d  = $urandom;
      te = (($urandom % 4) == 0) ? 9'($urandom) : 9'h0;
      rv = (($urandom % 4) == 0) ? 4'($urandom) : 4'h0;
      step(w, r, a, d, te, rv, "R5 R7 random");
    end
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule